// File: doc/BRIEF.md
# Gain-Dependent Input Sampling Strobe Generator

This block derives the timing strobes for an oversampling converter front end from one master clock. A free-running phase counter divides the master clock into fixed modulator cycles of 512 clocks. At the end of each cycle the block raises a one-cycle modulator strobe. That rate never changes with gain.

Inside each modulator cycle the block also emits a train of evenly spaced input-sample strobes. The number of strobes per cycle comes from a 3-bit gain code. It doubles for each code step up to code 3 and then stays at that value for the higher codes. A slot index tells the downstream sampling logic which input sample of the current cycle is in progress.

The gain code is captured only at a cycle boundary, so no cycle mixes two spacings. A sync pulse restarts the cycle from phase zero. All pins are plain control and timing signals. No data stream passes through the block, so it has no valid/ready handshake.

Top module: `sample_strobe_gen`

## Requirements
- R1: `mod_stb` is high for exactly one clock in every 512. Consecutive strobes are 512 clocks apart for every gain code.
- R2: The number of `smp_stb` pulses in one modulator cycle is 2 << min(code, 3), where code is the captured gain code. Codes 0,1,2,3 give 2, 4, 8 and 16 pulses. Codes 4 to 7 give 16 pulses.
- R3: Input-sample strobes are spaced S = 256 >> min(code, 3) clocks apart. With the phase p counting 0..511 from the clock after a cycle starts, `smp_stb` is high when p mod S equals S-1. The last strobe of a cycle therefore coincides with `mod_stb`.
- R4: `smp_idx` equals p / S. It is 0 in the first clock of a cycle, rises by one in the clock after each `smp_stb` within the cycle, and equals (512/S)-1 while `mod_stb` is high.
- R5: A change on `gain_sel` has no effect on the strobes or the index until the modulator cycle ends. The code present during the `mod_stb` clock governs the next whole cycle.
- R6: A `sync_pulse` sampled at a clock edge sets the phase to 0 and captures `gain_sel` at that edge. In the following clock `mod_stb` is low and `smp_idx` is 0. The first `mod_stb` after the sync comes 512 clocks after the previous cycle start implied by the sync edge, that is, in the 512th clock after the edge.
- R7: A synchronous reset (`rst` high at an edge) acts like a sync, including the capture of `gain_sel`. While `rst` is high and in the first clock after it, `mod_stb` is low and `smp_idx` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous reset, active high |
| gain_sel | input | 3 | Gain code 0..7 (gain 1 to 128), captured at cycle boundaries |
| sync_pulse | input | 1 | Restart: phase to zero, gain captured |
| mod_stb | output | 1 | One-clock modulator-cycle strobe |
| smp_stb | output | 1 | One-clock input-sample strobe |
| smp_idx | output | 4 | Input-sample slot within the current modulator cycle |

## Verification
Both strobes and the index are combinational decodes of the registered phase and captured gain. Each result is therefore due in the same clock in which the phase reaches the value that the requirement names. A gain code or sync captured at an edge shapes the outputs from the very next clock onward. The bench keeps a behavioural phase and gain model that it advances at every rising edge from the inputs sampled there. It compares all three outputs at each falling edge and tallies strobe counts and strobe intervals per cycle, so every latency is checked exactly and never within a tolerance.

// File: rtl/ssg_pkg.sv
package ssg_pkg;

  // Saturating exponent: the number of doublings a gain code applies to the
  // input sample rate, capped where the rate stops rising.
  function automatic int unsigned sat_shift(input int unsigned code,
                                            input int unsigned cap);
    return (code > cap) ? cap : code;
  endfunction

endpackage

// File: rtl/ssg_cycle_counter.sv
module ssg_cycle_counter #(
  parameter int unsigned CYCLE_LEN = 512,
  localparam int unsigned CYC_W = $clog2(CYCLE_LEN)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sync_i,
  output logic [CYC_W-1:0] phase_o,
  output logic             wrap_o
);

  logic [CYC_W-1:0] phase_q;

  assign wrap_o  = (phase_q == CYC_W'(CYCLE_LEN - 1));
  assign phase_o = phase_q;

  always_ff @(posedge clk) begin
    if (rst || sync_i || wrap_o) phase_q <= '0;
    else                          phase_q <= phase_q + 1'b1;
  end

  AST_PHASE_ADVANCE: assert property (@(posedge clk) disable iff (rst)
    (!sync_i && !wrap_o) |=> (phase_q == $past(phase_q) + 1'b1)); // R1

endmodule

// File: rtl/ssg_gain_latch.sv
module ssg_gain_latch
  import ssg_pkg::*;
#(
  parameter int unsigned GAIN_W    = 3,
  parameter int unsigned BASE_LOG  = 8,
  parameter int unsigned MAX_SHIFT = 3,
  localparam int unsigned SL_W = $clog2(BASE_LOG + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sync_i,
  input  logic              wrap_i,
  input  logic [GAIN_W-1:0] gain_i,
  output logic [SL_W-1:0]   slot_log_o
);

  logic [GAIN_W-1:0] code_q;

  always_ff @(posedge clk) begin
    if (rst || sync_i || wrap_i) code_q <= gain_i;
  end

  assign slot_log_o = SL_W'(BASE_LOG - sat_shift(int'(code_q), MAX_SHIFT));

  AST_GAIN_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(wrap_i) && !$past(sync_i)) |-> $stable(code_q)); // R5

endmodule

// File: rtl/ssg_slot_decode.sv
module ssg_slot_decode #(
  parameter int unsigned CYC_W = 9,
  parameter int unsigned SL_W  = 4,
  parameter int unsigned IDX_W = 4
) (
  input  logic [CYC_W-1:0] phase_i,
  input  logic [SL_W-1:0]  slot_log_i,
  output logic             smp_stb_o,
  output logic [IDX_W-1:0] smp_idx_o
);

  logic [CYC_W-1:0] low_mask;

  always_comb begin
    low_mask  = (CYC_W'(1) << slot_log_i) - CYC_W'(1);
    smp_stb_o = ((phase_i & low_mask) == low_mask);
    smp_idx_o = IDX_W'(phase_i >> slot_log_i);
  end

endmodule

// File: rtl/sample_strobe_gen.sv
module sample_strobe_gen #(
  parameter int unsigned CYCLE_LEN = 512,
  parameter int unsigned BASE_DIV  = 256,
  parameter int unsigned MAX_SHIFT = 3,
  parameter int unsigned GAIN_W    = 3,
  localparam int unsigned CYC_W    = $clog2(CYCLE_LEN),
  localparam int unsigned BASE_LOG = $clog2(BASE_DIV),
  localparam int unsigned SL_W     = $clog2(BASE_LOG + 1),
  localparam int unsigned IDX_W    = $clog2(CYCLE_LEN >> (BASE_LOG - MAX_SHIFT))
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [GAIN_W-1:0] gain_sel,
  input  logic              sync_pulse,
  output logic              mod_stb,
  output logic              smp_stb,
  output logic [IDX_W-1:0]  smp_idx
);

  logic [CYC_W-1:0] phase;
  logic             wrap;
  logic [SL_W-1:0]  slot_log;

  ssg_cycle_counter #(.CYCLE_LEN(CYCLE_LEN)) u_counter (
    .clk     (clk),
    .rst     (rst),
    .sync_i  (sync_pulse),
    .phase_o (phase),
    .wrap_o  (wrap)
  );

  ssg_gain_latch #(
    .GAIN_W    (GAIN_W),
    .BASE_LOG  (BASE_LOG),
    .MAX_SHIFT (MAX_SHIFT)
  ) u_gain (
    .clk        (clk),
    .rst        (rst),
    .sync_i     (sync_pulse),
    .wrap_i     (wrap),
    .gain_i     (gain_sel),
    .slot_log_o (slot_log)
  );

  ssg_slot_decode #(
    .CYC_W (CYC_W),
    .SL_W  (SL_W),
    .IDX_W (IDX_W)
  ) u_decode (
    .phase_i    (phase),
    .slot_log_i (slot_log),
    .smp_stb_o  (smp_stb),
    .smp_idx_o  (smp_idx)
  );

  assign mod_stb = wrap;

  AST_MOD_SINGLE: assert property (@(posedge clk) disable iff (rst)
    mod_stb |=> !mod_stb); // R1

  AST_MOD_HAS_SAMPLE: assert property (@(posedge clk) disable iff (rst)
    mod_stb |-> smp_stb); // R3

  AST_IDX_LAST: assert property (@(posedge clk) disable iff (rst)
    mod_stb |-> (smp_idx == IDX_W'((CYCLE_LEN >> slot_log) - 1))); // R4

  AST_IDX_STEP: assert property (@(posedge clk) disable iff (rst)
    (smp_stb && !mod_stb && !sync_pulse) |=> (smp_idx == $past(smp_idx) + 1'b1)); // R4

  AST_IDX_WRAP: assert property (@(posedge clk) disable iff (rst)
    mod_stb |=> (smp_idx == '0)); // R4

  AST_SYNC_RESTART: assert property (@(posedge clk) disable iff (rst)
    sync_pulse |=> (!mod_stb && smp_idx == '0)); // R6

endmodule

// File: tb/sample_strobe_gen_bench.sv
module sample_strobe_gen_bench;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       sync_pulse = 1'b0;
  logic [2:0] gain_sel = 3'd0;
  logic       mod_stb, smp_stb;
  logic [3:0] smp_idx;

  sample_strobe_gen u_sample_strobe_gen (
    .clk        (clk),
    .rst        (rst),
    .gain_sel   (gain_sel),
    .sync_pulse (sync_pulse),
    .mod_stb    (mod_stb),
    .smp_stb    (smp_stb),
    .smp_idx    (smp_idx)
  );

  always #10 clk = ~clk;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  // Behavioural model state, advanced at each rising edge.
  int ph = 0;
  int g = 0;
  int edges = 0;
  int last_mod = -1;
  int seen = 0;
  bit after_sync = 1'b0;

  always @(posedge clk) begin
    edges = edges + 1;
    if (rst || sync_pulse) begin
      ph = 0;
      g = int'(gain_sel);
      last_mod = edges - 1;
      seen = 0;
      after_sync = 1'b1;
    end else if (ph == 511) begin
      ph = 0;
      g = int'(gain_sel);
      seen = 0;
    end else begin
      ph = ph + 1;
    end
  end

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d at edge %0d", tag, what, act, exp, edges);
    end
  endtask

  task automatic step();
    int sp;
    @(negedge clk);
    sp = 256 >> ((g > 3) ? 3 : g);
    chk("R1", "mod_stb", int'(mod_stb), (ph == 511) ? 1 : 0);
    chk((int'(gain_sel) != g) ? "R5" : "R3", "smp_stb", int'(smp_stb),
        ((ph % sp) == sp - 1) ? 1 : 0);
    chk("R4", "smp_idx", int'(smp_idx), ph / sp);
    if (smp_stb) seen++;
    if (mod_stb) begin
      chk("R2", "samples per cycle", seen, 512 / sp);
      if (last_mod >= 0)
        chk(after_sync ? "R6" : "R1", "mod interval", edges - last_mod, 512);
      last_mod = edges;
      after_sync = 1'b0;
    end
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic pulse_sync(input logic [2:0] code);
    gain_sel = code;
    sync_pulse = 1'b1;
    step();
    sync_pulse = 1'b0;
  endtask

  initial begin
    run(3);
    rst = 1'b0;
    step();
    chk("R7", "mod_stb after reset", int'(mod_stb), 0);
    chk("R7", "smp_idx after reset", int'(smp_idx), 0);
    chk("R7", "smp_stb after reset", int'(smp_stb), 0);
    run(1100);
    // Mid-cycle gain change: old spacing must persist until the boundary.
    gain_sel = 3'd3;
    run(300);
    run(1100);
    for (int gc = 1; gc < 8; gc++) begin
      gain_sel = 3'(gc);
      run(700);
    end
    // Sync in the middle of a cycle, with a new code.
    pulse_sync(3'd2);
    chk("R6", "smp_idx after sync", int'(smp_idx), 0);
    chk("R6", "mod_stb after sync", int'(mod_stb), 0);
    run(1100);
    // Back-to-back sync pulses.
    pulse_sync(3'd1);
    pulse_sync(3'd6);
    pulse_sync(3'd0);
    run(1100);
    // Sync landing on the modulator strobe clock.
    while (!mod_stb) step();
    pulse_sync(3'd3);
    run(1100);
    // Reset in the middle of a run captures the code present at reset.
    gain_sel = 3'd5;
    rst = 1'b1;
    run(2);
    rst = 1'b0;
    step();
    chk("R7", "smp_idx after mid-run reset", int'(smp_idx), 0);
    gain_sel = 3'd1;
    run(1100);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(64'd20 * 64'd200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL R1 watchdog expired actual=%0d expected=%0d", edges, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule